// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block holds the pending state for two interrupt kinds aimed at a small group of CPUs: inter-processor interrupts, which one CPU raises for others, and periodic timer interrupts, which a tick input raises for every CPU. Each kind is a 4-bit pending vector with one bit per CPU slot. Each CPU gets one level output per kind, and that output is high while the matching bit is pending.

Software changes the state through a 64-bit register port. The port has a combined control register and three dedicated registers. A single control-register write can raise inter-processor interrupts, clear them, and clear timer interrupts, all in the same access. The block reports misuse rather than hiding it. A redundant request, or a clear of an inter-processor interrupt that is not pending, gives a one-cycle warning pulse. A write that asks for nothing gives a one-cycle error pulse.

The parameter `N_CPU` gives the number of CPUs that are present, from 1 to 4. Mask bits for slots that are not present are ignored.

Top module: `ipi_timer_intc`

## Requirements
- R1: After reset, both pending vectors are zero, all interrupt outputs are low, and `warn_pulse` and `err_pulse` are low.
- R2: A control write (`reg_sel`=0) with bits 15:12 set raises the inter-processor interrupt of CPU n (bit 12+n). The output is high from the clock edge that takes the write.
- R3: In a control write, bits 11:8 clear inter-processor interrupts and bits 7:4 clear timer interrupts (bit offset n selects CPU n). Several fields can act in one write. Within a write, the request is applied before the clear, so a CPU that is both requested and cleared ends up cleared, with no warning.
- R4: A request, through either register, for a CPU whose inter-processor interrupt is already pending leaves the state unchanged. `warn_pulse` is then high for the one cycle after the write edge.
- R5: A clear of an inter-processor interrupt that is not pending (after the request in the same write) raises `warn_pulse`. A clear of a timer interrupt that is not pending changes nothing and raises no pulse.
- R6: A control write with bit 28 set and nothing else is accepted with no effect. A control write that sets none of bits 15:4 and not bit 28 raises `err_pulse` for one cycle and changes no state. With no write, neither pulse rises.
- R7: A `tick` cycle makes the timer interrupt pending for every present CPU. Bits that are already pending stay set and raise no warning. If a tick and a timer clear arrive in the same cycle, the tick wins.
- R8: `reg_sel`=1 reads the inter-processor pending vector in bits 3:0 and clears the bits given by `wr_data[3:0]` on a write. `reg_sel`=2 does the same for the timer vector. `reg_sel`=3 raises inter-processor interrupts for the mask in `wr_data[3:0]` on a write and reads as zero.
- R9: A write to `reg_sel` 1, 2 or 3 with `wr_data[3:0]` all zero raises `err_pulse` and changes no state.
- R10: A control read returns the inter-processor pending vector in bits 11:8, the timer vector in bits 7:4 and `req_cpu` in bits 1:0. All other bits are zero. `rd_data` is zero while `rd_en` is low.
- R11: Mask bits for CPU slots at index `N_CPU` and above change no state and raise no pulse. The outputs of those slots stay low, even after a tick.
- R12: `reg_sel` codes 4 to 7 are not registers. A write to one of them raises `err_pulse` and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 IPI pending/clear, 2 timer pending/clear, 3 IPI request |
| wr_data | input | 64 | Write data |
| req_cpu | input | 2 | Identifier of the CPU making the access |
| rd_data | output | 64 | Read data (combinational) |
| tick | input | 1 | Timer tick, one cycle per period |
| ipi_irq | output | 4 | Per-CPU inter-processor interrupt level |
| tmr_irq | output | 4 | Per-CPU timer interrupt level |
| warn_pulse | output | 1 | One-cycle pulse on a redundant request or an empty IPI clear |
| err_pulse | output | 1 | One-cycle pulse on an empty or unsupported write |

## Verification
The bench targets the ordering cases.

- **Request and clear for one CPU in one control write.** Applying the clear first would leave the interrupt pending and warn of a stray clear.
- **Tick in the same cycle as a timer clear.** Letting the clear win would drop a timer interrupt.
- **Warning asymmetry.** An empty timer clear must stay silent while an empty inter-processor clear warns. A design that treats the two alike shows a wrong pulse.
- **Absent CPU slots.** Masks that name only an absent slot must cause neither state nor warning; a design that does not mask them shows a stray output or pulse.
- **Empty-write rules.** The lone bit-28 acknowledge must not raise an error, while an empty mask to a dedicated register must.

// File: rtl/ipitmr_pkg.sv
package ipitmr_pkg;
  localparam int CPU_SLOTS = 4;
  localparam int WORD_W    = 64;

  typedef logic [CPU_SLOTS-1:0] cpu_vec_t;

  // Register select codes seen on reg_sel
  localparam logic [2:0] SEL_CTRL      = 3'd0;
  localparam logic [2:0] SEL_IPI_PEND  = 3'd1;
  localparam logic [2:0] SEL_TMR_PEND  = 3'd2;
  localparam logic [2:0] SEL_IPI_RAISE = 3'd3;

  // Control register field positions
  localparam int F_IPI_REQ = 12;
  localparam int F_IPI_CLR = 8;
  localparam int F_TMR_CLR = 4;
  localparam int F_ACK     = 28;
  localparam int F_MASK    = 0;
endpackage

// File: rtl/ipitmr_wdec.sv
module ipitmr_wdec
  import ipitmr_pkg::*;
#(
  parameter int N_CPU = 3
) (
  input  logic              wr_en,
  input  logic [2:0]        sel,
  input  logic [WORD_W-1:0] data,
  output cpu_vec_t          ipi_set,
  output cpu_vec_t          ipi_clr,
  output cpu_vec_t          tmr_clr,
  output logic              bad
);
  localparam cpu_vec_t LIVE = cpu_vec_t'((1 << N_CPU) - 1);

  cpu_vec_t req_f, iclr_f, tclr_f, mask_f;
  logic     ack_f;
  logic     unused_hi;

  assign req_f     = data[F_IPI_REQ +: CPU_SLOTS];
  assign iclr_f    = data[F_IPI_CLR +: CPU_SLOTS];
  assign tclr_f    = data[F_TMR_CLR +: CPU_SLOTS];
  assign mask_f    = data[F_MASK    +: CPU_SLOTS];
  assign ack_f     = data[F_ACK];
  assign unused_hi = ^{data[WORD_W-1:F_ACK+1], data[F_ACK-1:F_IPI_REQ+CPU_SLOTS]};

  always_comb begin
    ipi_set = '0;
    ipi_clr = '0;
    tmr_clr = '0;
    bad     = 1'b0;
    if (wr_en) begin
      case (sel)
        SEL_CTRL: begin
          ipi_set = req_f  & LIVE;
          ipi_clr = iclr_f & LIVE;
          tmr_clr = tclr_f & LIVE;
          bad     = ~((|req_f) | (|iclr_f) | (|tclr_f) | ack_f);
        end
        SEL_IPI_PEND: begin
          ipi_clr = mask_f & LIVE;
          bad     = ~(|mask_f);
        end
        SEL_TMR_PEND: begin
          tmr_clr = mask_f & LIVE;
          bad     = ~(|mask_f);
        end
        SEL_IPI_RAISE: begin
          ipi_set = mask_f & LIVE;
          bad     = ~(|mask_f);
        end
        default: bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/ipitmr_pend.sv
module ipitmr_pend
  import ipitmr_pkg::*;
#(
  parameter int N_CPU    = 3,
  parameter bit SET_LAST = 1'b0,
  parameter bit REPORT   = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  cpu_vec_t set_m,
  input  cpu_vec_t clr_m,
  output cpu_vec_t pend,
  output logic     dup_set,
  output logic     stray_clr
);
  localparam cpu_vec_t LIVE = cpu_vec_t'((1 << N_CPU) - 1);

  cpu_vec_t pend_q, pend_d;
  logic     upd;

  assign upd = |(set_m | clr_m);

  generate
    if (SET_LAST) begin : g_set_last
      always_comb pend_d = ((pend_q & ~clr_m) | set_m) & LIVE;
    end else begin : g_clr_last
      always_comb pend_d = ((pend_q | set_m) & ~clr_m) & LIVE;
    end

    if (REPORT) begin : g_report
      always_comb begin
        dup_set   = |(set_m & pend_q);
        stray_clr = |(clr_m & ~(pend_q | set_m));
      end
    end else begin : g_quiet
      always_comb begin
        dup_set   = 1'b0;
        stray_clr = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= '0;
    else if (upd) pend_q <= pend_d;
  end

  assign pend = pend_q;

  // R11
  ghost_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~LIVE) == '0);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_m == '0 && clr_m == '0) |=> $stable(pend_q));

  generate
    if (SET_LAST) begin : g_chk_set
      // R7
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_m) |=> ((pend_q & $past(set_m)) == $past(set_m)));
    end else begin : g_chk_clr
      // R3
      clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_m) |=> ((pend_q & $past(clr_m)) == '0));
    end
  endgenerate
endmodule

// File: rtl/ipi_timer_intc.sv
module ipi_timer_intc
  import ipitmr_pkg::*;
#(
  parameter int N_CPU = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        reg_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [1:0]        req_cpu,
  output logic [WORD_W-1:0] rd_data,
  input  logic              tick,
  output logic [3:0]        ipi_irq,
  output logic [3:0]        tmr_irq,
  output logic              warn_pulse,
  output logic              err_pulse
);
  localparam cpu_vec_t LIVE = cpu_vec_t'((1 << N_CPU) - 1);

  cpu_vec_t ipi_set, ipi_clr, tmr_clr, tmr_set;
  cpu_vec_t ipi_pend, tmr_pend;
  logic     bad_wr;
  logic     ipi_dup, ipi_stray, tmr_dup, tmr_stray;
  logic     warn_d, err_d, warn_q, err_q;

  ipitmr_wdec #(.N_CPU(N_CPU)) u_wdec (
    .wr_en   (wr_en),
    .sel     (reg_sel),
    .data    (wr_data),
    .ipi_set (ipi_set),
    .ipi_clr (ipi_clr),
    .tmr_clr (tmr_clr),
    .bad     (bad_wr)
  );

  assign tmr_set = tick ? LIVE : '0;

  ipitmr_pend #(.N_CPU(N_CPU), .SET_LAST(1'b0), .REPORT(1'b1)) u_ipi (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_m     (ipi_set),
    .clr_m     (ipi_clr),
    .pend      (ipi_pend),
    .dup_set   (ipi_dup),
    .stray_clr (ipi_stray)
  );

  ipitmr_pend #(.N_CPU(N_CPU), .SET_LAST(1'b1), .REPORT(1'b0)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_m     (tmr_set),
    .clr_m     (tmr_clr),
    .pend      (tmr_pend),
    .dup_set   (tmr_dup),
    .stray_clr (tmr_stray)
  );

  always_comb begin
    warn_d = ipi_dup | ipi_stray | tmr_dup | tmr_stray;
    err_d  = bad_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      warn_q <= warn_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (reg_sel)
        SEL_CTRL: begin
          rd_data[F_IPI_CLR +: CPU_SLOTS] = ipi_pend;
          rd_data[F_TMR_CLR +: CPU_SLOTS] = tmr_pend;
          rd_data[1:0]                    = req_cpu;
        end
        SEL_IPI_PEND: rd_data[F_MASK +: CPU_SLOTS] = ipi_pend;
        SEL_TMR_PEND: rd_data[F_MASK +: CPU_SLOTS] = tmr_pend;
        default:      rd_data = '0;
      endcase
    end
  end

  assign ipi_irq    = ipi_pend;
  assign tmr_irq    = tmr_pend;
  assign warn_pulse = warn_q;
  assign err_pulse  = err_q;

  // R7
  tick_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((tmr_irq & LIVE) == LIVE));

  // R6
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!err_pulse && !warn_pulse));

  // R6
  err_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == SEL_CTRL && wr_data[15:4] == '0) |=> $stable(ipi_irq));
endmodule

// File: tb/test_ipi_timer_intc.sv
`timescale 1ns/1ps
module test_ipi_timer_intc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en, tick;
  logic [2:0]  reg_sel;
  logic [63:0] wr_data;
  logic [1:0]  req_cpu;
  logic [63:0] rd_data;
  logic [3:0]  ipi_irq, tmr_irq;
  logic        warn_pulse, err_pulse;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  ipi_timer_intc #(.N_CPU(3)) i_ipi_timer_intc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .reg_sel(reg_sel), .wr_data(wr_data), .req_cpu(req_cpu),
    .rd_data(rd_data), .tick(tick), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq),
    .warn_pulse(warn_pulse), .err_pulse(err_pulse)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive a write (optionally with tick) for one edge, sample after it
  task automatic wr(input logic [2:0] sel, input logic [63:0] d, input logic tk);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = sel; wr_data = d; tick = tk;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0; wr_data = '0;
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, input logic [1:0] cpu, output logic [63:0] v);
    @(negedge clk);
    rd_en = 1'b1; reg_sel = sel; req_cpu = cpu;
    #2 v = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    check("R1 ipi", {60'd0, ipi_irq}, 64'h0);
    check("R1 tmr", {60'd0, tmr_irq}, 64'h0);
    check("R1 warn", {63'd0, warn_pulse}, 64'h0);
    check("R1 err", {63'd0, err_pulse}, 64'h0);
    rd(3'd0, 2'd3, v);
    check("R1/R10 ctrl read", v, 64'h3);
  endtask

  task automatic t_ipi_ctrl();
    wr(3'd0, 64'h3000, 1'b0);
    check("R2 request", {60'd0, ipi_irq}, 64'h3);
    check("R2 no warn", {63'd0, warn_pulse}, 64'h0);
    wr(3'd0, 64'h1000, 1'b0);
    check("R4 dup state", {60'd0, ipi_irq}, 64'h3);
    check("R4 dup warn", {63'd0, warn_pulse}, 64'h1);
    @(negedge clk);
    check("R4 warn one cycle", {63'd0, warn_pulse}, 64'h0);
    wr(3'd0, 64'h4000, 1'b0);
    check("R2 request cpu2", {60'd0, ipi_irq}, 64'h7);
    wr(3'd0, 64'h0100, 1'b0);
    check("R3 clear cpu0", {60'd0, ipi_irq}, 64'h6);
    wr(3'd0, 64'h0100, 1'b0);
    check("R5 empty ipi clear warn", {63'd0, warn_pulse}, 64'h1);
    check("R5 empty ipi clear state", {60'd0, ipi_irq}, 64'h6);
    wr(3'd0, 64'h1100, 1'b0);
    check("R3 req then clear", {60'd0, ipi_irq}, 64'h6);
    check("R3 req then clear no warn", {63'd0, warn_pulse}, 64'h0);
  endtask

  task automatic t_timer();
    do_tick();
    check("R7 tick", {60'd0, tmr_irq}, 64'h7);
    do_tick();
    check("R7 tick again", {60'd0, tmr_irq}, 64'h7);
    check("R7 no warn", {63'd0, warn_pulse}, 64'h0);
    check("R11 absent slot after tick", {63'd0, tmr_irq[3]}, 64'h0);
    wr(3'd0, 64'h0010, 1'b0);
    check("R3 timer clear", {60'd0, tmr_irq}, 64'h6);
    wr(3'd0, 64'h0010, 1'b0);
    check("R5 empty timer clear state", {60'd0, tmr_irq}, 64'h6);
    check("R5 empty timer clear silent", {62'd0, warn_pulse, err_pulse}, 64'h0);
    wr(3'd2, 64'h2, 1'b0);
    check("R8 timer reg clear", {60'd0, tmr_irq}, 64'h4);
    wr(3'd2, 64'h4, 1'b1);
    check("R7 tick beats clear", {60'd0, tmr_irq}, 64'h7);
    wr(3'd0, 64'h0F00_0000_0000_0F70, 1'b0);
    check("R3 multi field ipi", {60'd0, ipi_irq}, 64'h0);
    check("R3 multi field tmr", {60'd0, tmr_irq}, 64'h0);
    wr(3'd0, 64'h6000, 1'b0);
    do_tick();
  endtask

  task automatic t_misc();
    wr(3'd0, 64'h1000_0000, 1'b0);
    check("R6 ack no err", {63'd0, err_pulse}, 64'h0);
    check("R6 ack no change", {56'd0, ipi_irq, tmr_irq}, 64'h67);
    wr(3'd0, 64'h1, 1'b0);
    check("R6 empty ctrl err", {63'd0, err_pulse}, 64'h1);
    check("R6 empty ctrl no change", {56'd0, ipi_irq, tmr_irq}, 64'h67);
  endtask

  task automatic t_dedicated();
    logic [63:0] v;
    wr(3'd3, 64'h1, 1'b0);
    check("R8 raise reg", {60'd0, ipi_irq}, 64'h7);
    wr(3'd3, 64'h2, 1'b0);
    check("R4 raise reg dup warn", {63'd0, warn_pulse}, 64'h1);
    rd(3'd1, 2'd0, v);
    check("R8 ipi read", v, 64'h7);
    wr(3'd1, 64'h5, 1'b0);
    check("R8 ipi reg clear", {60'd0, ipi_irq}, 64'h2);
    wr(3'd3, 64'h0, 1'b0);
    check("R9 empty raise err", {63'd0, err_pulse}, 64'h1);
    check("R9 empty raise state", {60'd0, ipi_irq}, 64'h2);
    wr(3'd2, 64'hF0, 1'b0);
    check("R9 empty tmr clear err", {63'd0, err_pulse}, 64'h1);
    check("R9 empty tmr clear state", {60'd0, tmr_irq}, 64'h7);
    rd(3'd3, 2'd0, v);
    check("R8 raise reg reads zero", v, 64'h0);
  endtask

  task automatic t_read();
    logic [63:0] v;
    rd(3'd0, 2'd2, v);
    check("R10 ctrl read", v, 64'h272);
    rd(3'd2, 2'd0, v);
    check("R8 tmr read", v, 64'h7);
    @(negedge clk);
    reg_sel = 3'd0;
    #2 check("R10 idle read zero", rd_data, 64'h0);
  endtask

  task automatic t_absent();
    wr(3'd3, 64'h8, 1'b0);
    check("R11 absent raise state", {60'd0, ipi_irq}, 64'h2);
    check("R11 absent raise pulses", {62'd0, warn_pulse, err_pulse}, 64'h0);
    wr(3'd0, 64'h8000, 1'b0);
    check("R11 absent ctrl raise", {60'd0, ipi_irq}, 64'h2);
    check("R11 absent ctrl pulses", {62'd0, warn_pulse, err_pulse}, 64'h0);
    wr(3'd1, 64'h8, 1'b0);
    check("R11 absent clear no warn", {62'd0, warn_pulse, err_pulse}, 64'h0);
  endtask

  task automatic t_badsel();
    logic [63:0] v;
    wr(3'd5, 64'hF, 1'b0);
    check("R12 bad sel err", {63'd0, err_pulse}, 64'h1);
    check("R12 bad sel state", {56'd0, ipi_irq, tmr_irq}, 64'h27);
    rd(3'd6, 2'd1, v);
    check("R12 bad sel read", v, 64'h0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; tick = 1'b0;
    reg_sel = '0; wr_data = '0; req_cpu = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ipi_ctrl();
    t_timer();
    t_misc();
    t_dedicated();
    t_read();
    t_absent();
    t_badsel();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end
endmodule